// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Overlay

This block draws a 64 by 64 pixel pointer on top of a raster pixel stream. On each clock the display pipeline presents the current beam column and line, plus the 24-bit pixel it would show there. The block returns that pixel one clock later. Where the pointer covers the pixel, it returns one of three programmable cursor colours instead. The pointer pattern uses two bits per pixel and lives in a 512-word store of 16-bit words. Code 0 in the pattern is see-through.

The pointer origin comes from one packed register with a horizontal and a vertical field. Each field is 12 bits wide and is read as a two's-complement number. This lets the pointer hang off the left or top edge of the screen: only the part at non-negative screen coordinates is drawn. A group of high control bits, fed in from the owning display controller, hides the pointer whenever any of those bits is set.

Top module: `hwcur_overlay`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, pix_out is 0. Reset also sets the origin to (0,0) and all three colour registers to 0.
- R2: The block passes the incoming pixel through unchanged in either of two cases: the beam position lies outside the pointer footprint, or the pattern code at that position is 0.
- R3: Pattern codes 1, 2 and 3 replace the pixel with colour register 1, 2 or 3. Colour registers and pixel buses share one packing: red in bits 7:0, green in bits 15:8 and blue in bits 23:16.
- R4: Pointer column c of pointer line l reads pattern word address l*8 + c/8. Within that word, the code sits in bits 2*(c%8)+1 : 2*(c%8), so the pixel shown first comes from bits 1:0.
- R5: The footprint spans columns ox to ox+63 and lines oy to oy+63. Beam positions at ox+64 or oy+64 pass the pixel through.
- R6: The origin register carries X in bits 23:12 and Y in bits 11:0. A field whose bit 11 is set means (field & 0x7FF) - 0x800. When the origin is negative, screen column 0 shows pointer column -ox, and screen line 0 shows pointer line -oy.
- R7: When any bit of cur_ctl_hi is set (these are control bits 31:23), every pixel passes through unchanged. Bit 22 and below of the control word have no effect.
- R8: A colour write with index 0 changes none of the three colour registers.
- R9: pix_out reflects the beam position and pixel presented one clock earlier, and it holds that value until the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern store write strobe |
| pat_addr | input | 9 | Pattern word address (line*8 + word) |
| pat_wdata | input | 16 | Pattern word, eight 2-bit codes |
| col_we | input | 1 | Colour register write strobe |
| col_idx | input | 2 | Colour register index (1..3; 0 is ignored) |
| col_wdata | input | 24 | Colour value, R 7:0, G 15:8, B 23:16 |
| pos_we | input | 1 | Origin register write strobe |
| pos_wdata | input | 24 | Packed origin, X 23:12, Y 11:0 |
| cur_ctl_hi | input | 9 | Control bits 31:23; any set hides the pointer |
| beam_x | input | 12 | Current beam column |
| beam_y | input | 12 | Current beam line |
| pix_in | input | 24 | Underlying pixel |
| pix_out | output | 24 | Merged pixel, one clock later |

## Verification
The bench probes the last pointer column and line, and the first column and line past the footprint. An off-by-one compare there would either clip the pointer one pixel short or paint a stray pixel stripe. It also sets a pattern bit in the last word of a middle line, which catches a design that picks codes from the wrong end of a word or that builds the store address the wrong way round. A negative origin with a marked pattern on line 1 exposes a design that treats bit 11 as magnitude rather than sign; such a design would place the pointer far to the right and leave screen (0,0) untouched. Index-0 colour writes and control bit 22 are driven to show that neither disturbs the output.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
   localparam int CH_W = 8;
   typedef logic [3*CH_W-1:0] rgb_t;
   typedef enum logic [1:0] {
      CODE_CLEAR = 2'd0,
      CODE_C1    = 2'd1,
      CODE_C2    = 2'd2,
      CODE_C3    = 2'd3
   } cur_code_e;
endpackage

// File: rtl/hwcur_pat_ram.sv
module hwcur_pat_ram #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 512,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   initial begin
      depth_pow2_chk: assert ((1 << ADDR_W) == DEPTH)
         else $error("pattern depth must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/hwcur_pos_reg.sv
module hwcur_pos_reg #(
   parameter int COORD_W = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pos_we,
   input  logic [2*COORD_W-1:0]       pos_wdata,
   output logic signed [COORD_W-1:0]  org_x,
   output logic signed [COORD_W-1:0]  org_y
);
   logic [2*COORD_W-1:0] raw_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      raw_q <= '0;
      else if (pos_we) raw_q <= pos_wdata;
   end

   // top bit of each field weighs -2^(COORD_W-1): plain two's complement
   assign org_x = $signed(raw_q[2*COORD_W-1:COORD_W]);
   assign org_y = $signed(raw_q[COORD_W-1:0]);

   // R6
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pos_we |=> ($stable(org_x) && $stable(org_y)));
endmodule

// File: rtl/hwcur_col_regs.sv
module hwcur_col_regs #(
   parameter int IDX_W = 2,
   parameter int RGB_W = 24,
   localparam int NCOL = (1 << IDX_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             col_we,
   input  logic [IDX_W-1:0] col_idx,
   input  logic [RGB_W-1:0] col_wdata,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [RGB_W-1:0] rd_col
);
   logic [RGB_W-1:0] col_q [1:NCOL];

   for (genvar i = 1; i <= NCOL; i++) begin : g_col
      always_ff @(posedge clk) begin
         if (!rst_n)                                  col_q[i] <= '0;
         else if (col_we && col_idx == IDX_W'(i))     col_q[i] <= col_wdata;
      end

      // R8
      reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (col_we && col_idx != IDX_W'(i)) |=> $stable(col_q[i]));
   end

   always_comb begin
      rd_col = '0;
      for (int i = 1; i <= NCOL; i++) begin
         if (rd_idx == IDX_W'(i)) rd_col = col_q[i];
      end
   end
endmodule

// File: rtl/hwcur_locate.sv
module hwcur_locate #(
   parameter int COORD_W      = 12,
   parameter int CUR_W        = 64,
   parameter int CUR_H        = 64,
   parameter int PIX_PER_WORD = 8,
   localparam int DW     = COORD_W + 2,
   localparam int XW     = $clog2(CUR_W),
   localparam int YW     = $clog2(CUR_H),
   localparam int SW     = $clog2(PIX_PER_WORD),
   localparam int ADDR_W = YW + XW - SW
) (
   input  logic [COORD_W-1:0]        beam_x,
   input  logic [COORD_W-1:0]        beam_y,
   input  logic signed [COORD_W-1:0] org_x,
   input  logic signed [COORD_W-1:0] org_y,
   output logic                      hit,
   output logic [ADDR_W-1:0]         rd_addr,
   output logic [SW-1:0]             pix_sel
);
   logic signed [DW-1:0] dx, dy;
   logic in_x, in_y;

   initial begin
      shape_chk: assert ((1 << XW) == CUR_W && (1 << YW) == CUR_H &&
                         (1 << SW) == PIX_PER_WORD && XW >= SW)
         else $error("cursor size and word packing must be powers of two");
   end

   always_comb begin
      dx   = $signed({2'b00, beam_x}) - {{2{org_x[COORD_W-1]}}, org_x};
      dy   = $signed({2'b00, beam_y}) - {{2{org_y[COORD_W-1]}}, org_y};
      in_x = !dx[DW-1] && (dx[DW-2:0] < (DW-1)'(CUR_W));
      in_y = !dy[DW-1] && (dy[DW-2:0] < (DW-1)'(CUR_H));
   end

   assign hit     = in_x && in_y;
   assign rd_addr = {dy[YW-1:0], dx[XW-1:SW]};
   assign pix_sel = dx[SW-1:0];
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
   import hwcur_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int CUR_W   = 64,
   parameter int CUR_H   = 64,
   parameter int BPP     = 2,
   parameter int WORD_W  = 16,
   parameter int CTL_HI  = 9,
   parameter bit OUT_REG = 1'b1,
   localparam int PPW    = WORD_W / BPP,
   localparam int WPL    = CUR_W / PPW,
   localparam int DEPTH  = CUR_H * WPL,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int SW     = $clog2(PPW),
   localparam int RGB_W  = $bits(rgb_t)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pat_we,
   input  logic [ADDR_W-1:0]    pat_addr,
   input  logic [WORD_W-1:0]    pat_wdata,
   input  logic                 col_we,
   input  logic [BPP-1:0]       col_idx,
   input  logic [RGB_W-1:0]     col_wdata,
   input  logic                 pos_we,
   input  logic [2*COORD_W-1:0] pos_wdata,
   input  logic [CTL_HI-1:0]    cur_ctl_hi,
   input  logic [COORD_W-1:0]   beam_x,
   input  logic [COORD_W-1:0]   beam_y,
   input  logic [RGB_W-1:0]     pix_in,
   output logic [RGB_W-1:0]     pix_out
);
   initial begin
      pack_chk: assert (WORD_W % BPP == 0 && CUR_W % PPW == 0)
         else $error("pattern word must hold whole pixels and whole lines");
   end

   logic signed [COORD_W-1:0] org_x, org_y;
   logic                      hit;
   logic [ADDR_W-1:0]         rd_addr;
   logic [SW-1:0]             pix_sel;
   logic [WORD_W-1:0]         rd_word;
   logic [BPP-1:0]            code;
   logic [RGB_W-1:0]          cur_col;
   logic                      show;
   rgb_t                      merged;

   hwcur_pat_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
      .raddr(rd_addr), .rdata(rd_word));

   hwcur_pos_reg #(.COORD_W(COORD_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .pos_we(pos_we), .pos_wdata(pos_wdata),
      .org_x(org_x), .org_y(org_y));

   hwcur_locate #(.COORD_W(COORD_W), .CUR_W(CUR_W), .CUR_H(CUR_H),
                  .PIX_PER_WORD(PPW)) u_loc (
      .beam_x(beam_x), .beam_y(beam_y), .org_x(org_x), .org_y(org_y),
      .hit(hit), .rd_addr(rd_addr), .pix_sel(pix_sel));

   hwcur_col_regs #(.IDX_W(BPP), .RGB_W(RGB_W)) u_col (
      .clk(clk), .rst_n(rst_n), .col_we(col_we), .col_idx(col_idx),
      .col_wdata(col_wdata), .rd_idx(code), .rd_col(cur_col));

   always_comb begin
      code   = rd_word[pix_sel*BPP +: BPP];
      show   = ~|cur_ctl_hi;
      merged = (show && hit && code != BPP'(CODE_CLEAR)) ? cur_col : pix_in;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) pix_out <= '0;
         else        pix_out <= merged;
      end

      // R7
      hidden_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|cur_ctl_hi) |=> pix_out == $past(pix_in));
      // R2
      outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !hit |=> pix_out == $past(pix_in));
      // R2
      clear_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (code == BPP'(CODE_CLEAR)) |=> pix_out == $past(pix_in));
   end else begin : g_comb
      assign pix_out = merged;
   end
endmodule

// File: tb/hwcur_overlay_bench.sv
module hwcur_overlay_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pat_we = 1'b0;
   logic [8:0]  pat_addr = '0;
   logic [15:0] pat_wdata = '0;
   logic        col_we = 1'b0;
   logic [1:0]  col_idx = '0;
   logic [23:0] col_wdata = '0;
   logic        pos_we = 1'b0;
   logic [23:0] pos_wdata = '0;
   logic [8:0]  cur_ctl_hi = '0;
   logic [11:0] beam_x = '0;
   logic [11:0] beam_y = '0;
   logic [23:0] pix_in = '0;
   logic [23:0] pix_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [23:0] C1 = 24'h0000FF;
   localparam logic [23:0] C2 = 24'h00FF00;
   localparam logic [23:0] C3 = 24'hFF0000;
   localparam logic [23:0] BG = 24'h5A3C96;

   always #(CLK_PERIOD/2) clk = ~clk;

   hwcur_overlay u_hwcur_overlay (
      .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
      .pat_wdata(pat_wdata), .col_we(col_we), .col_idx(col_idx),
      .col_wdata(col_wdata), .pos_we(pos_we), .pos_wdata(pos_wdata),
      .cur_ctl_hi(cur_ctl_hi), .beam_x(beam_x), .beam_y(beam_y),
      .pix_in(pix_in), .pix_out(pix_out));

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_pat(input int addr, input logic [15:0] d);
      @(negedge clk); pat_we = 1'b1; pat_addr = 9'(addr); pat_wdata = d;
      @(negedge clk); pat_we = 1'b0;
   endtask

   task automatic wr_col(input logic [1:0] idx, input logic [23:0] d);
      @(negedge clk); col_we = 1'b1; col_idx = idx; col_wdata = d;
      @(negedge clk); col_we = 1'b0;
   endtask

   task automatic wr_pos(input logic [11:0] x, input logic [11:0] y);
      @(negedge clk); pos_we = 1'b1; pos_wdata = {x, y};
      @(negedge clk); pos_we = 1'b0;
   endtask

   // present one pixel, check merged result one clock later
   task automatic pix(input string req, input int x, input int y,
                      input logic [23:0] pin, input logic [23:0] exp);
      @(negedge clk); beam_x = 12'(x); beam_y = 12'(y); pix_in = pin;
      @(negedge clk); chk(req, pix_out, exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 in reset", pix_out, 24'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", pix_out, 24'h0);
   endtask

   task automatic t_latency();
      wr_pos(12'd2000, 12'd2000);
      @(negedge clk); beam_x = 12'd5; beam_y = 12'd5; pix_in = 24'h123456;
      @(negedge clk);
      chk("R9 first value", pix_out, 24'h123456);
      pix_in = 24'h654321;
      #1 chk("R9 holds until edge", pix_out, 24'h123456);
      @(negedge clk);
      chk("R9 second value", pix_out, 24'h654321);
      pix("R2 outside footprint", 1999, 2000, BG, BG);
   endtask

   task automatic t_codes();
      wr_col(2'd1, C1); wr_col(2'd2, C2); wr_col(2'd3, C3);
      wr_pat(0, 16'h0039);             // codes 1,2,3,0 in pixels 0..3
      wr_pos(12'd100, 12'd50);
      pix("R3 code1", 100, 50, BG, C1);
      pix("R3 code2", 101, 50, BG, C2);
      pix("R3 code3", 102, 50, BG, C3);
      pix("R2 code0 clear", 103, 50, BG, BG);
      pix("R5 left of footprint", 99, 50, BG, BG);
   endtask

   task automatic t_order();
      wr_pat(5*8 + 7, 16'h8000);       // line 5, word 7, pixel 7 code 2
      pix("R4 last pixel of word 7", 163, 55, BG, C2);
      pix("R4 pixel 6 of word 7", 162, 55, BG, BG);
      pix("R4 word 0 of line 5", 100, 55, BG, BG);
   endtask

   task automatic t_edges();
      wr_pat(63*8 + 7, 16'hFFFF);
      pix("R5 last corner", 163, 113, BG, C3);
      pix("R5 column past end", 164, 113, BG, BG);
      pix("R5 line past end", 163, 114, BG, BG);
   endtask

   task automatic t_negative();
      wr_pat(1*8 + 0, 16'h0010);       // line 1, pixel 2 code 1
      wr_pos(12'hFFE, 12'hFFF);        // x = -2, y = -1
      pix("R6 clipped origin shows col2 line1", 0, 0, BG, C1);
      pix("R6 clipped col3 clear", 1, 0, BG, BG);
      pix("R6 line0 hidden above screen", 2, 1, BG, BG);
      wr_pos(12'd100, 12'd50);
   endtask

   task automatic t_hide();
      @(negedge clk); cur_ctl_hi = 9'h001;   // control bit 23
      pix("R7 bit23 hides", 100, 50, BG, BG);
      @(negedge clk); cur_ctl_hi = 9'h100;   // control bit 31
      pix("R7 bit31 hides", 101, 50, BG, BG);
      @(negedge clk); cur_ctl_hi = 9'h000;   // bit 22 is not on this port
      pix("R7 shown when clear", 100, 50, BG, C1);
   endtask

   task automatic t_idx0();
      wr_col(2'd0, 24'hABCDEF);
      pix("R8 c1 kept", 100, 50, BG, C1);
      pix("R8 c2 kept", 101, 50, BG, C2);
      pix("R8 c3 kept", 102, 50, BG, C3);
      wr_col(2'd1, 24'h445566);
      pix("R3 c1 rewritten", 100, 50, BG, 24'h445566);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_latency();
      t_codes();
      t_order();
      t_edges();
      t_negative();
      t_hide();
      t_idx0();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule